// File: doc/BRIEF.md
# UART Channel Interrupt Status Collector

This block gathers the interrupt requests of four serial channels and three device-wide sources (wake-up, general-purpose pin events and a timer) into one 32-bit status word. The low byte of the word holds one bit per channel that is set while that channel has anything pending. Above the low byte, each channel has a 3-bit field that names its most urgent pending source. A single combined interrupt line is high whenever any channel bit is set.

Each source is latched when its request line is high at a clock edge. The latch stays set until the matching acknowledge strobe is sampled high. The acknowledge strobe stands for a read of the register that services that source. When one source is acknowledged, the channel's field moves on to the next pending source. The three device-wide sources appear only in channel 0. A channel-0 field of 000 with channel bit 0 set means the wake-up source is pending.

Top module: `uart_irq_gather`

## Requirements
- R1: Bit c of irq_word (c = 0..3) is 1 exactly when channel c has at least one latched source. For channel 0 this includes the wake-up, pin and timer latches. Bits [7:4] are always 0.
- R2: Channel c's 3-bit code sits at irq_word[8+3c +: 3], so channel 0 uses [10:8] and channel 3 uses [19:17]. Bits [31:20] are always 0.
- R3: A receive request latches when rx_rdy[c] is high or any of the four bits line_err[4c +: 4] is high. While it is latched, the channel's code is 001, which outranks every other source.
- R4: The other per-channel codes are receive time-out 010, transmit empty 011 and modem/flow event 100, in that order of precedence. Code 101 is never produced.
- R5: The pin event (code 110) and the timer event (code 111) appear only in channel 0's field. They rank below the modem event, and the pin event ranks above the timer event.
- R6: A latched wake-up gives channel-0 code 000 with irq_word[0] set. It ranks below every other channel-0 source.
- R7: An acknowledge strobe sampled at a clock edge clears only its own latch, and the status word shows this after that edge. The field then shows the next pending source. An acknowledge for a source that is not pending changes nothing.
- R8: If a source's request and its acknowledge are sampled at the same edge, the source stays pending.
- R9: irq_any equals the OR of irq_word[3:0].
- R10: A synchronous active-high rst clears every latch, so irq_word is 0 after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_rdy | input | 4 | Per-channel receive data ready request |
| line_err | input | 16 | Per-channel receive error flags, 4 per channel |
| rx_tmo | input | 4 | Per-channel receive time-out request |
| tx_empty | input | 4 | Per-channel transmit empty request |
| modem_evt | input | 4 | Per-channel modem, flow-control or special character event |
| wake_evt | input | 1 | Device wake-up request |
| gpio_evt | input | 1 | Device pin event request |
| tmr_evt | input | 1 | Device timer/counter request |
| ack_rx | input | 4 | Per-channel clear of the receive latch |
| ack_tmo | input | 4 | Per-channel clear of the time-out latch |
| ack_tx | input | 4 | Per-channel clear of the transmit-empty latch |
| ack_modem | input | 4 | Per-channel clear of the modem event latch |
| ack_wake | input | 1 | Clear of the wake-up latch |
| ack_gpio | input | 1 | Clear of the pin event latch |
| ack_tmr | input | 1 | Clear of the timer latch |
| irq_word | output | 32 | Global interrupt status word |
| irq_any | output | 1 | Combined interrupt line |

## Verification
A single request on one channel at a time shows that each field lands in the right slice and that the right summary bit is set. An error flag used alone, without data ready, shows that all four flags feed the receive code. Several sources raised together, then acknowledged one at a time, trace the whole precedence chain of one channel. The same is done for the device-wide sources in channel 0, down to the wake-up-only state. A request and its acknowledge on the same edge show that the set wins. A mismatched acknowledge shows that a clear touches only its own latch. Requests on all channels at once, followed by a mid-run reset, show that the fields are independent and that reset clears everything.

// File: rtl/uart_irq_gather.sv
module uart_irq_gather #(
  parameter int NCH  = 4,
  parameter int ERRW = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        rx_rdy,
  input  logic [NCH*ERRW-1:0]   line_err,
  input  logic [NCH-1:0]        rx_tmo,
  input  logic [NCH-1:0]        tx_empty,
  input  logic [NCH-1:0]        modem_evt,
  input  logic                  wake_evt,
  input  logic                  gpio_evt,
  input  logic                  tmr_evt,
  input  logic [NCH-1:0]        ack_rx,
  input  logic [NCH-1:0]        ack_tmo,
  input  logic [NCH-1:0]        ack_tx,
  input  logic [NCH-1:0]        ack_modem,
  input  logic                  ack_wake,
  input  logic                  ack_gpio,
  input  logic                  ack_tmr,
  output logic [31:0]           irq_word,
  output logic                  irq_any
);
  localparam int SUM_W    = 8;
  localparam int CODE_W   = 3;
  localparam int CODE_LSB = SUM_W;

  localparam logic [CODE_W-1:0] C_NONE  = 3'b000;
  localparam logic [CODE_W-1:0] C_RX    = 3'b001;
  localparam logic [CODE_W-1:0] C_TMO   = 3'b010;
  localparam logic [CODE_W-1:0] C_TX    = 3'b011;
  localparam logic [CODE_W-1:0] C_MODEM = 3'b100;
  localparam logic [CODE_W-1:0] C_GPIO  = 3'b110;
  localparam logic [CODE_W-1:0] C_TMR   = 3'b111;

  logic [NCH-1:0]        summ;
  logic [NCH*CODE_W-1:0] codes;
  logic                  p_wake, p_gpio, p_tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_wake <= 1'b0;
      p_gpio <= 1'b0;
      p_tmr  <= 1'b0;
    end else begin
      p_wake <= wake_evt | (p_wake & ~ack_wake);
      p_gpio <= gpio_evt | (p_gpio & ~ack_gpio);
      p_tmr  <= tmr_evt  | (p_tmr  & ~ack_tmr);
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic l_rx, l_tmo, l_tx, l_mod;
    logic [CODE_W-1:0] local_code;
    logic [CODE_W-1:0] code;
    logic              any_local;

    always_ff @(posedge clk) begin
      if (rst) begin
        l_rx  <= 1'b0;
        l_tmo <= 1'b0;
        l_tx  <= 1'b0;
        l_mod <= 1'b0;
      end else begin
        l_rx  <= rx_rdy[c] | (|line_err[c*ERRW +: ERRW]) | (l_rx & ~ack_rx[c]);
        l_tmo <= rx_tmo[c]    | (l_tmo & ~ack_tmo[c]);
        l_tx  <= tx_empty[c]  | (l_tx  & ~ack_tx[c]);
        l_mod <= modem_evt[c] | (l_mod & ~ack_modem[c]);
      end
    end

    assign any_local  = l_rx | l_tmo | l_tx | l_mod;
    assign local_code = l_rx  ? C_RX    :
                        l_tmo ? C_TMO   :
                        l_tx  ? C_TX    :
                        l_mod ? C_MODEM : C_NONE;

    if (c == 0) begin : g_dev
      assign code    = any_local ? local_code :
                       p_gpio    ? C_GPIO     :
                       p_tmr     ? C_TMR      : C_NONE;
      assign summ[c] = any_local | p_gpio | p_tmr | p_wake;
    end else begin : g_plain
      assign code    = local_code;
      assign summ[c] = any_local;
    end

    assign codes[c*CODE_W +: CODE_W] = code;
  end

  always_comb begin
    irq_word = '0;
    irq_word[NCH-1:0] = summ;
    irq_word[CODE_LSB +: NCH*CODE_W] = codes;
  end

  assign irq_any = |summ;
endmodule

// File: rtl/uart_irq_gather_chk.sv
module uart_irq_gather_chk #(
  parameter int NCH  = 4,
  parameter int ERRW = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [NCH-1:0]      rx_rdy,
  input logic [NCH*ERRW-1:0] line_err,
  input logic [NCH-1:0]      tx_empty,
  input logic [NCH-1:0]      ack_rx,
  input logic [NCH-1:0]      ack_tx,
  input logic [31:0]         irq_word,
  input logic                irq_any
);
  localparam int FIRST_PAD = 8 + 3*NCH;

  assert_any_R9: assert property (@(posedge clk) disable iff (rst)
    irq_any == (|irq_word[NCH-1:0]));

  assert_pad_R2: assert property (@(posedge clk) disable iff (rst)
    irq_word[31:FIRST_PAD] == '0 && irq_word[7:NCH] == '0);

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> irq_word == 32'd0);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_rx_code_R3: assert property (@(posedge clk) disable iff (rst)
      rx_rdy[c] |=> (irq_word[8+3*c +: 3] == 3'b001 && irq_word[c]));

    assert_no_reserved_R4: assert property (@(posedge clk) disable iff (rst)
      irq_word[8+3*c +: 3] != 3'b101);

    assert_ack_R7: assert property (@(posedge clk) disable iff (rst)
      (ack_rx[c] && !rx_rdy[c] && line_err[c*ERRW +: ERRW] == '0)
        |=> irq_word[8+3*c +: 3] != 3'b001);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
      (tx_empty[c] && ack_tx[c]) |=> irq_word[c]);

    if (c > 0) begin : g_far
      assert_chan_local_R5: assert property (@(posedge clk) disable iff (rst)
        irq_word[8+3*c+1 +: 2] != 2'b11);

      assert_summary_R1: assert property (@(posedge clk) disable iff (rst)
        (irq_word[8+3*c +: 3] == 3'b000) == !irq_word[c]);
    end
  end
endmodule

bind uart_irq_gather uart_irq_gather_chk #(.NCH(NCH), .ERRW(ERRW)) u_chk (
  .clk(clk), .rst(rst), .rx_rdy(rx_rdy), .line_err(line_err),
  .tx_empty(tx_empty), .ack_rx(ack_rx), .ack_tx(ack_tx),
  .irq_word(irq_word), .irq_any(irq_any)
);

// File: tb/test_uart_irq_gather.sv
module test_uart_irq_gather;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rx_rdy, rx_tmo, tx_empty, modem_evt;
  logic [15:0] line_err;
  logic        wake_evt, gpio_evt, tmr_evt;
  logic [3:0]  ack_rx, ack_tmo, ack_tx, ack_modem;
  logic        ack_wake, ack_gpio, ack_tmr;
  logic [31:0] irq_word;
  logic        irq_any;

  int vectors = 0;
  int errors  = 0;

  always #10 clk = ~clk;

  uart_irq_gather i_uart_irq_gather (
    .clk(clk), .rst(rst), .rx_rdy(rx_rdy), .line_err(line_err),
    .rx_tmo(rx_tmo), .tx_empty(tx_empty), .modem_evt(modem_evt),
    .wake_evt(wake_evt), .gpio_evt(gpio_evt), .tmr_evt(tmr_evt),
    .ack_rx(ack_rx), .ack_tmo(ack_tmo), .ack_tx(ack_tx), .ack_modem(ack_modem),
    .ack_wake(ack_wake), .ack_gpio(ack_gpio), .ack_tmr(ack_tmr),
    .irq_word(irq_word), .irq_any(irq_any)
  );

  task automatic idle_inputs();
    rx_rdy = '0; rx_tmo = '0; tx_empty = '0; modem_evt = '0; line_err = '0;
    wake_evt = 0; gpio_evt = 0; tmr_evt = 0;
    ack_rx = '0; ack_tmo = '0; ack_tx = '0; ack_modem = '0;
    ack_wake = 0; ack_gpio = 0; ack_tmr = 0;
  endtask

  // inputs are set before the call; one rising edge samples them
  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic check(input logic [31:0] exp, input string req);
    vectors++;
    if (irq_word !== exp || irq_any !== (|exp[3:0])) begin
      errors++;
      $display("FAIL %s: irq_word=%h irq_any=%b expected %h / %b",
               req, irq_word, irq_any, exp, |exp[3:0]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check(32'h0, "R10 reset state");
  endtask

  task automatic t_single_rx();
    do_reset();
    rx_rdy[1] = 1; step();
    check(32'h0000_0802, "R1 R2 R3 rx on channel 1");
  endtask

  task automatic t_line_err();
    do_reset();
    line_err[11] = 1; step();
    check(32'h0000_4004, "R3 line error on channel 2");
    ack_tx[2] = 1; step();
    check(32'h0000_4004, "R7 unrelated ack leaves rx pending");
    ack_rx[2] = 1; step();
    check(32'h0, "R7 rx ack clears");
  endtask

  task automatic t_chain();
    do_reset();
    rx_tmo[3] = 1; tx_empty[3] = 1; modem_evt[3] = 1; step();
    check(32'h0004_0008, "R4 timeout outranks tx and modem");
    ack_tmo[3] = 1; step();
    check(32'h0006_0008, "R4 R7 tx after timeout ack");
    ack_tx[3] = 1; step();
    check(32'h0008_0008, "R4 R7 modem after tx ack");
    ack_modem[3] = 1; step();
    check(32'h0, "R7 channel 3 empty");
  endtask

  task automatic t_device();
    do_reset();
    gpio_evt = 1; tmr_evt = 1; wake_evt = 1; step();
    check(32'h0000_0601, "R5 pin event outranks timer");
    ack_gpio = 1; step();
    check(32'h0000_0701, "R5 timer after pin ack");
    ack_tmr = 1; step();
    check(32'h0000_0001, "R6 wake-up only");
    modem_evt[0] = 1; step();
    check(32'h0000_0401, "R5 R6 modem outranks device sources");
    ack_modem[0] = 1; step();
    check(32'h0000_0001, "R6 wake-up remains");
    ack_wake = 1; step();
    check(32'h0, "R6 wake-up cleared");
  endtask

  task automatic t_set_wins();
    do_reset();
    tx_empty[1] = 1; step();
    check(32'h0000_1802, "R4 tx on channel 1");
    tx_empty[1] = 1; ack_tx[1] = 1; step();
    check(32'h0000_1802, "R8 request wins over ack");
    ack_tx[1] = 1; step();
    check(32'h0, "R7 tx ack clears");
  endtask

  task automatic t_all_rx();
    do_reset();
    rx_rdy = 4'hF; tmr_evt = 1; step();
    check(32'h0002_490F, "R1 R2 R3 rx on all channels");
    rst = 1; step(); rst = 0;
    check(32'h0, "R10 reset while pending");
  endtask

  initial begin
    idle_inputs();
    t_reset();
    t_single_rx();
    t_line_err();
    t_chain();
    t_device();
    t_set_wins();
    t_all_rx();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    vectors++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule